// File: doc/BRIEF.md
# Cascadable LCD Segment Column Driver Core

This block is the digital core of an 80-column segment driver for a dot-matrix LCD panel. A display controller sends one line as 4-bit nibbles on a slow shift clock. The block gathers each nibble into a first-stage line register. A direction input sets the column order in which the nibbles are placed. A falling edge of the line-load strobe copies the gathered line into a second-stage register. From that register the block encodes a 2-bit drive-level code for every column, using the latched bit, an alternation input and a display-enable input.

Several of these drivers can share one data bus through a chip-disable chain. A chip takes data only while its chip-disable input is low. After it has taken a full line, it pulls its chip-disable output low, which enables the next chip in the chain. It then ignores the shift clock until the next load strobe. The shift clock and load strobe are asynchronous to the fast system clock. Each one passes through a synchronizer and a falling-edge detector.

Top module: `seg_column_drv`

## Requirements
- R1: After reset, `cd_out` is 1, every second-stage bit is 0 and the nibble position is the first one.
- R2: With `dir_in` = 0, the n-th accepted nibble (n = 0..19) puts `data_in[i]` (i = 0..3) into column 77 - 4n + i. Columns are numbered 1..80.
- R3: With `dir_in` = 1, the n-th accepted nibble puts `data_in[i]` into column 4n + 4 - i.
- R4: A shift-clock falling edge seen while `cd_in` = 1 is ignored. It neither writes data nor advances the nibble position.
- R5: `cd_out` stays 1 while fewer than 20 nibbles have been accepted. It goes to 0 once the 20th nibble has been accepted.
- R6: Once 20 nibbles have been accepted, further shift-clock falling edges are ignored until the next load-strobe falling edge.
- R7: A load-strobe falling edge does three things. It copies the first-stage line into the second stage. It returns the nibble position to the first one. It sets `cd_out` back to 1. If a load edge and a shift edge fall in the same cycle, the load edge wins.
- R8: With `disp_on_in` = 1, the code for column c is taken from `lvl_out[2(c-1)+1 : 2(c-1)]`. The latched bit Q and `alt_in` select it as follows: alt 0 / Q 0 gives 1 (V3); alt 0 / Q 1 gives 0 (V1); alt 1 / Q 0 gives 2 (V4); alt 1 / Q 1 gives 3 (VEE).
- R9: With `disp_on_in` = 0, every column code is 0 (V1), whatever the data and `alt_in` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Shift clock; a nibble is taken on its falling edge |
| load_in | input | 1 | Line-load strobe; acts on its falling edge |
| data_in | input | 4 | Display data nibble; bit i is the i-th data line |
| dir_in | input | 1 | Column order select |
| cd_in | input | 1 | Chip disable from the previous chip; 1 blocks data intake |
| alt_in | input | 1 | Drive alternation signal |
| disp_on_in | input | 1 | 0 forces every column to code 0 |
| cd_out | output | 1 | Chip disable toward the next chip |
| lvl_out | output | 160 | Two-bit drive-level code per column, column 1 in the lowest bits |

## Verification
A falling edge on `sclk_in` or `load_in` reaches the registers three system-clock edges after it occurs. That time covers two synchronizer flops and one edge-history flop. So the nibble position, `cd_out` and the second-stage line settle three cycles after the edge. `lvl_out` follows `alt_in` and `disp_on_in` within the same cycle, because it is combinational from the second stage. The bench holds `data_in`, `dir_in` and `cd_in` steady for four cycles after each shift-clock fall and keeps `load_in` low for five cycles. It samples outputs on the falling system-clock edge, after at least five cycles have passed since the last strobe edge. Every check therefore reads a value that has settled.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;
  localparam int COLS       = 80;
  localparam int NIB_W      = 4;
  localparam int GROUPS     = COLS / NIB_W;
  localparam int POS_W      = $clog2(GROUPS);
  localparam int LVL_W      = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_V1  = 2'd0,
    LVL_V3  = 2'd1,
    LVL_V4  = 2'd2,
    LVL_VEE = 2'd3
  } lvl_code_t;

  // Column group written by the nibble at position pos.
  function automatic logic [POS_W-1:0] group_of(input logic [POS_W-1:0] pos, input logic dir);
    group_of = dir ? pos : POS_W'(GROUPS - 1) - pos;
  endfunction

  // Data line that feeds lane j of a group.
  function automatic int lane_src(input int j, input logic dir);
    lane_src = dir ? (NIB_W - 1 - j) : j;
  endfunction

  // Drive-level code of one column.
  function automatic lvl_code_t level_of(input logic q, input logic alt, input logic on);
    if (!on)      level_of = LVL_V1;
    else if (alt) level_of = q ? LVL_VEE : LVL_V4;
    else          level_of = q ? LVL_V1  : LVL_V3;
  endfunction
endpackage

// File: rtl/seg_fall_det.sv
module seg_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], sig_in};
  end

  assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import lcdseg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_fall,
  input  logic             load_fall,
  input  logic             cd_in,
  input  logic             dir,
  output logic             wr_en,
  output logic [POS_W-1:0] wr_group,
  output logic             cd_out
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(GROUPS - 1);

  logic [POS_W-1:0] pos;
  logic             full;
  logic             accept;
  logic             last_nib;

  assign accept   = shift_fall & ~cd_in & ~full & ~load_fall;
  assign last_nib = accept & (pos == LAST_POS);
  assign wr_en    = accept;
  assign wr_group = group_of(pos, dir);
  assign cd_out   = ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      full <= 1'b0;
    end else if (load_fall) begin
      pos  <= '0;
      full <= 1'b0;
    end else if (accept) begin
      if (last_nib) begin
        pos  <= '0;
        full <= 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST_POS);
  p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_in && !load_fall) |=> $stable(pos) && $stable(full));
  p_last_drops_cd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_nib |=> !cd_out);
  p_full_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cd_out && !load_fall) |=> !cd_out && pos == '0);
  p_load_rearms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall |=> cd_out && pos == '0);
endmodule

// File: rtl/seg_line_latch.sv
module seg_line_latch
  import lcdseg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [POS_W-1:0] wr_group,
  input  logic             dir,
  input  logic [NIB_W-1:0] data,
  input  logic             load_fall,
  output logic [COLS-1:0]  line_q
);
  logic [COLS-1:0] line_acc;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic sel;
    assign sel = wr_en && (wr_group == POS_W'(g));
    for (genvar j = 0; j < NIB_W; j++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   line_acc[g*NIB_W+j] <= 1'b0;
        else if (sel) line_acc[g*NIB_W+j] <= data[lane_src(j, dir)];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         line_q <= '0;
    else if (load_fall) line_q <= line_acc;
  end

  p_copy_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall |=> line_q == $past(line_acc));
  p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fall |=> $stable(line_q));
endmodule

// File: rtl/seg_level_enc.sv
module seg_level_enc
  import lcdseg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [COLS-1:0]       line_q,
  input  logic                  alt,
  input  logic                  disp_on,
  output logic [COLS*LVL_W-1:0] lvl
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign lvl[c*LVL_W +: LVL_W] = level_of(line_q[c], alt, disp_on);
  end

  p_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> lvl == '0);
  p_first_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_on |-> (lvl[1] == alt) && (lvl[0] == (alt ~^ line_q[0])));
endmodule

// File: rtl/seg_column_drv.sv
module seg_column_drv
  import lcdseg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_in,
  input  logic                  load_in,
  input  logic [NIB_W-1:0]      data_in,
  input  logic                  dir_in,
  input  logic                  cd_in,
  input  logic                  alt_in,
  input  logic                  disp_on_in,
  output logic                  cd_out,
  output logic [COLS*LVL_W-1:0] lvl_out
);
  logic             shift_fall;
  logic             load_fall;
  logic             wr_en;
  logic [POS_W-1:0] wr_group;
  logic [COLS-1:0]  line_q;

  seg_fall_det #(.STAGES(SYNC_STAGES)) u_sclk_det (
    .clk(clk), .rst_n(rst_n), .sig_in(sclk_in), .fall(shift_fall));

  seg_fall_det #(.STAGES(SYNC_STAGES)) u_load_det (
    .clk(clk), .rst_n(rst_n), .sig_in(load_in), .fall(load_fall));

  seg_addr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .shift_fall(shift_fall), .load_fall(load_fall),
    .cd_in(cd_in), .dir(dir_in), .wr_en(wr_en), .wr_group(wr_group),
    .cd_out(cd_out));

  seg_line_latch u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_group(wr_group),
    .dir(dir_in), .data(data_in), .load_fall(load_fall), .line_q(line_q));

  seg_level_enc u_enc (
    .clk(clk), .rst_n(rst_n), .line_q(line_q), .alt(alt_in),
    .disp_on(disp_on_in), .lvl(lvl_out));

  p_no_write_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cd_out |-> !wr_en);
  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> cd_out && line_q == '0);
endmodule

// File: tb/seg_column_drv_test.sv
module seg_column_drv_test;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         sclk_in = 0, load_in = 0;
  logic [3:0]   data_in = 0;
  logic         dir_in = 0, cd_in = 0, alt_in = 0, disp_on_in = 1;
  logic         cd_out;
  logic [159:0] lvl_out;

  int checks = 0, fails = 0;
  bit acc_line [1:80];   // first stage as the bench expects it
  bit shown    [1:80];   // second stage as the bench expects it
  int taken;             // nibbles taken in the current line

  always #2.5 clk = ~clk;

  seg_column_drv uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_code(input bit q, input bit alt, input bit on);
    if (!on) return 0;
    case ({alt, q})
      2'b00: return 1;
      2'b01: return 0;
      2'b10: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_nib(input bit [3:0] d);
    data_in = d;
    sclk_in = 1;
    settle(3);
    sclk_in = 0;
    settle(4);
    if (!cd_in && taken < 20) begin
      for (int i = 0; i < 4; i++) begin
        int col;
        col = dir_in ? (4 * taken + 4 - i) : (77 - 4 * taken + i);
        acc_line[col] = d[i];
      end
      taken++;
    end
  endtask

  task automatic pulse_load();
    load_in = 1;
    settle(3);
    load_in = 0;
    settle(5);
    for (int c = 1; c <= 80; c++) shown[c] = acc_line[c];
    taken = 0;
  endtask

  task automatic check_levels(input string req);
    int bad_c, bad_a, bad_e;
    bad_c = 0;
    bad_a = 0;
    bad_e = 0;
    for (int c = 1; c <= 80; c++) begin
      int e, a;
      e = exp_code(shown[c], alt_in, disp_on_in);
      a = int'(lvl_out[2*(c-1) +: 2]);
      if (a != e && bad_c == 0) begin
        bad_c = c;
        bad_a = a;
        bad_e = e;
      end
    end
    check(bad_c == 0, req, $sformatf("column %0d code", bad_c), bad_a, bad_e);
  endtask

  task automatic fill_line(input int seed);
    for (int n = 0; n < 20; n++) shift_nib(4'((n * 7 + seed) & 15));
  endtask

  // R1: reset state
  task automatic t_reset();
    check(cd_out == 1, "R1", "cd_out after reset", cd_out, 1);
    alt_in = 0;
    disp_on_in = 1;
    settle(1);
    check_levels("R1");
  endtask

  // R2, R8: downward order, all four level codes
  task automatic t_dir_low();
    dir_in = 0;
    fill_line(3);
    pulse_load();
    alt_in = 0;
    settle(1);
    check_levels("R2");
    alt_in = 1;
    settle(1);
    check_levels("R8");
    // column 80 holds bit 3 of nibble 0 (value 3 -> 0), column 77 bit 0 -> 1
    check(lvl_out[159:158] == 2, "R2", "column 80 code", lvl_out[159:158], 2);
    check(lvl_out[153:152] == 3, "R2", "column 77 code", lvl_out[153:152], 3);
    alt_in = 0;
  endtask

  // R3, R9: upward order and display-off override
  task automatic t_dir_high();
    dir_in = 1;
    fill_line(10);
    pulse_load();
    settle(1);
    check_levels("R3");
    // nibble 0 = 10 (1010): data bit 0 -> column 4 = 0, data bit 1 -> column 3 = 1
    check(lvl_out[7:6] == 1, "R3", "column 4 code", lvl_out[7:6], 1);
    check(lvl_out[5:4] == 0, "R3", "column 3 code", lvl_out[5:4], 0);
    disp_on_in = 0;
    alt_in = 1;
    settle(1);
    check(lvl_out == '0, "R9", "blank all columns", lvl_out[31:0], 0);
    check_levels("R9");
    disp_on_in = 1;
    alt_in = 0;
    settle(1);
  endtask

  // R4: shift edges while disabled leave position and data alone
  task automatic t_disabled();
    dir_in = 0;
    cd_in = 1;
    for (int n = 0; n < 3; n++) shift_nib(4'hF);
    check(cd_out == 1, "R4", "cd_out while disabled", cd_out, 1);
    cd_in = 0;
    fill_line(5);
    pulse_load();
    settle(1);
    check_levels("R4");
  endtask

  // R5, R6, R7: cascade handshake, extra clocks, re-arm
  task automatic t_cascade();
    dir_in = 1;
    for (int n = 0; n < 19; n++) shift_nib(4'(n + 1));
    check(cd_out == 1, "R5", "cd_out after 19 nibbles", cd_out, 1);
    shift_nib(4'h6);
    check(cd_out == 0, "R5", "cd_out after 20 nibbles", cd_out, 0);
    shift_nib(4'h9);
    shift_nib(4'hC);
    check(cd_out == 0, "R6", "cd_out after extra clocks", cd_out, 0);
    pulse_load();
    check(cd_out == 1, "R7", "cd_out after load", cd_out, 1);
    settle(1);
    check_levels("R6");
    // partial line then load: position restarts at the first group
    for (int n = 0; n < 5; n++) shift_nib(4'h3);
    pulse_load();
    fill_line(1);
    check(cd_out == 0, "R7", "cd_out after full line following restart", cd_out, 0);
    pulse_load();
    settle(1);
    check_levels("R7");
  endtask

  initial begin
    for (int c = 1; c <= 80; c++) begin
      acc_line[c] = 0;
      shown[c] = 0;
    end
    taken = 0;
    settle(3);
    rst_n = 1;
    settle(3);
    t_reset();
    t_dir_low();
    t_dir_high();
    t_disabled();
    t_cascade();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule